// File: doc/BRIEF.md
# Key-Protected Clock Control Register Bank

This block is the register front end of a clock-generation peripheral. It is a 32-bit memory-mapped slave with a window of 0x2000 bytes. It holds the settings for five PLLs and sixteen PLL output channels. Frequency arithmetic, the real PLLs and the clock muxes sit elsewhere. Those consumers watch this bank's update strobes and recompute only what a write touched.

Software must place a fixed key, 0x5A, in bits [31:24] of every write. A write that lacks the key is dropped. When a write is accepted, the key bits are removed before the value is stored. Each PLL has the following registers:

- one manager register, whose bit 8 is the analog reset;
- an analog group of six registers: control (bit 16 is power-down), fraction, and four tuning words.

Each channel has one control register. One word reports the lock state of every PLL. It is computed live from the power-down and analog-reset bits.

Register map (byte offsets):

| Register | Byte offset |
|---|---|
| Lock status | 0x080 |
| Manager register of PLL p | 0x100 + 4p |
| Analog group of PLL p | 0x1000 + 32p, slots 0..5 at +4k (slot 0 control, slot 1 fraction, slots 2..5 tuning) |
| Control register of channel c | 0x1200 + 4c |

Top module: `clkbank_regs`

## Requirements
- R1: A write whose bits [31:24] are not 0x5A changes no stored register and raises no update strobe.
- R2: An accepted write stores bits [23:0]. A later read of that offset returns the stored bits with [31:24] equal to zero.
- R3: Only word-aligned accesses take effect, and the register index is bus_addr[12:2]. A write with bus_addr[1:0] not equal to zero is ignored, and a read at such an address returns zero.
- R4: A read of byte offset 0x080 returns the lock word. Bit p (p = 0..4) is 1 when bit 16 of PLL p's control register and bit 8 of PLL p's manager register are both 0. Bits [31:5] are 0, and any value written at that offset is never returned.
- R5: An accepted write to PLL p's manager register (byte 0x100 + 4p) sets pll_upd[p]. It also sets chan_upd for every channel whose parent is PLL p.
- R6: An accepted write to slot k (k = 0..5) of PLL p's analog group (byte 0x1000 + 32p + 4k) sets pll_upd[p] only, with chan_upd zero.
- R7: An accepted write to channel c's control register (byte 0x1200 + 4c) sets chan_upd[c] only, with pll_upd zero.
- R8: Reset clears every stored register to zero and clears both strobe vectors.
- R9: The channel parents are fixed:

  | Channels | Parent PLL |
  |---|---|
  | 0 to 3 | 0 |
  | 4 to 7 | 1 |
  | 8 to 11 | 2 |
  | 12 to 14 | 3 |
  | 15 | 4 |
- R10: Strobes appear in the cycle after the accepted write and last one cycle. Writes to unmapped offsets, including analog slots 6 and 7 and the lock offset, are stored but raise no strobe.
- R11: Read data appears on bus_rdata in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 32 | Write data including key field |
| bus_rdata | output | 32 | Registered read data |
| pll_upd | output | 5 | One-cycle per-PLL update strobes |
| chan_upd | output | 16 | One-cycle per-channel update strobes |

## Verification
The assertions check these behaviours on every cycle:
- a keyless or misaligned write is never followed by a strobe;
- at most one PLL strobe is raised at a time;
- a channel-only strobe names a single channel;
- the lock inputs change only after an accepted write;
- read data stays stable between reads.

Only the bench scenarios can show the following:
- the key is stripped from stored values;
- the lock word follows the power-down and reset bits;
- the parent map puts the right channels on each manager write;
- unmapped offsets store their data silently;
- reset really clears storage.

// File: rtl/clkbank_pkg.sv
// Shared constants and helpers for the clock control register bank.
// Assumes a 32-bit bus, an 8-bit key at the top of the write data and
// word indices of 11 bits (0x2000-byte window).
package clkbank_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned KEY_W    = 8;
    localparam int unsigned ADDR_W   = 13;
    localparam int unsigned IDX_W    = ADDR_W - 2;
    localparam int unsigned DEPTH    = 1 << IDX_W;
    localparam int unsigned STORE_W  = DATA_W - KEY_W;
    localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;

    localparam int unsigned NUM_PLL  = 5;
    localparam int unsigned NUM_CHAN = 16;

    // Word-index layout of the bank
    localparam int unsigned LOCK_IDX = 'h020;
    localparam int unsigned MGR_BASE = 'h040;
    localparam int unsigned ANA_BASE = 'h400;
    localparam int unsigned ANA_GRP  = 8;
    localparam int unsigned ANA_USED = 6;
    localparam int unsigned CH_BASE  = 'h480;

    // Control bit positions feeding the lock word
    localparam int unsigned PD_BIT   = 16;
    localparam int unsigned ARST_BIT = 8;

    // Number of channels owned by each PLL, in PLL order
    localparam int unsigned CHAN_CNT [NUM_PLL] = '{4, 4, 4, 3, 1};

    // Parent PLL of a channel, derived from the per-PLL channel counts
    function automatic int unsigned chan_parent(input int unsigned ch);
        int unsigned acc;
        int unsigned par;
        acc = 0;
        par = NUM_PLL - 1;
        for (int p = NUM_PLL - 1; p >= 0; p--) begin
            acc = 0;
            for (int q = 0; q < p; q++) acc += CHAN_CNT[q];
            if (ch >= acc && ch < acc + CHAN_CNT[p]) par = p;
        end
        return par;
    endfunction
endpackage

// File: rtl/clkbank_gate.sv
// Access qualifier: decides whether a bus cycle is an accepted write or a
// valid read. It strips the key field from the write value.
// Assumes one access per cycle, at most.
module clkbank_gate
    import clkbank_pkg::*;
(
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               wr_ok,
    output logic               rd_req,
    output logic               rd_aligned,
    output logic [IDX_W-1:0]   idx,
    output logic [STORE_W-1:0] wval
);
    logic aligned;
    logic key_match;

    // Classify the current bus cycle
    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        key_match  = (wdata[DATA_W-1 -: KEY_W] == WR_KEY);
        wr_ok      = sel && wr && aligned && key_match;
        rd_req     = sel && !wr;
        rd_aligned = aligned;
        idx        = addr[ADDR_W-1:2];
        wval       = wdata[STORE_W-1:0];
    end
endmodule

// File: rtl/clkbank_store.sv
// Register storage and registered read port. It holds the key-free part of
// every word and builds the lock word from the PLL control bits.
// Assumes reads and writes never occur in the same cycle.
module clkbank_store
    import clkbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic               rd_req,
    input  logic               rd_aligned,
    input  logic [IDX_W-1:0]   idx,
    input  logic [STORE_W-1:0] wval,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_PLL-1:0] lock
);
    logic [STORE_W-1:0] mem [DEPTH];

    // Derive each PLL's lock bit from its power-down and analog-reset bits
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock
        localparam int unsigned CTRL_I = ANA_BASE + p * ANA_GRP;
        localparam int unsigned MGR_I  = MGR_BASE + p;
        assign lock[p] = !mem[CTRL_I][PD_BIT] && !mem[MGR_I][ARST_BIT];
    end

    // Storage update and clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[idx] <= wval;
        end
    end

    // Registered read data, with the lock word substituted at its index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_req) begin
            if (!rd_aligned)
                rdata <= '0;
            else if (idx == IDX_W'(LOCK_IDX))
                rdata <= DATA_W'(lock);
            else
                rdata <= {{KEY_W{1'b0}}, mem[idx]};
        end
    end

    // R1: lock inputs only move after an accepted write
    p_lock_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(lock));

    // R11: read data holds between read requests
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rdata));
endmodule

// File: rtl/clkbank_strobe.sv
// Update strobe decoder. It maps the index of an accepted write to
// one-cycle PLL and channel strobes. A manager write also fans out to the
// channels of that PLL. Assumes at most one write per cycle.
module clkbank_strobe
    import clkbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ok,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_PLL-1:0]  pll_upd,
    output logic [NUM_CHAN-1:0] chan_upd
);
    logic [NUM_PLL-1:0]  pll_nx;
    logic [NUM_CHAN-1:0] chan_nx;
    logic [NUM_PLL-1:0]  mgr_hit;

    // Per-PLL decode of manager and analog-group hits
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        localparam int unsigned GRP_LO = ANA_BASE + p * ANA_GRP;
        localparam int unsigned GRP_HI = GRP_LO + ANA_USED;
        logic ana_hit;
        assign mgr_hit[p] = wr_ok && (idx == IDX_W'(MGR_BASE + p));
        assign ana_hit    = wr_ok && (idx >= IDX_W'(GRP_LO)) && (idx < IDX_W'(GRP_HI));
        assign pll_nx[p]  = mgr_hit[p] || ana_hit;
    end

    // Per-channel decode: its own register or its parent's manager register
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        localparam int unsigned PAR = chan_parent(c);
        assign chan_nx[c] = (wr_ok && (idx == IDX_W'(CH_BASE + c))) || mgr_hit[PAR];
    end

    // Register the strobes so they last exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_upd  <= '0;
            chan_upd <= '0;
        end else begin
            pll_upd  <= pll_nx;
            chan_upd <= chan_nx;
        end
    end

    // R5: a single write never names more than one PLL
    p_one_pll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pll_upd));

    // R7: without a PLL strobe, at most one channel is strobed
    p_chan_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_upd == '0) |-> ($countones(chan_upd) <= 1));
endmodule

// File: rtl/clkbank_regs.sv
// Top of the key-protected clock control register bank. It joins the
// access qualifier, the storage with its lock word, and the strobe decoder.
// Assumes a single-cycle 32-bit bus: read data is registered, and writes
// complete in the cycle they are presented.
module clkbank_regs
    import clkbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PLL-1:0]  pll_upd,
    output logic [NUM_CHAN-1:0] chan_upd
);
    logic               wr_ok;
    logic               rd_req;
    logic               rd_aligned;
    logic [IDX_W-1:0]   idx;
    logic [STORE_W-1:0] wval;
    logic [NUM_PLL-1:0] lock;

    clkbank_gate u_gate (
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wr_ok      (wr_ok),
        .rd_req     (rd_req),
        .rd_aligned (rd_aligned),
        .idx        (idx),
        .wval       (wval)
    );

    clkbank_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .rd_req     (rd_req),
        .rd_aligned (rd_aligned),
        .idx        (idx),
        .wval       (wval),
        .rdata      (bus_rdata),
        .lock       (lock)
    );

    clkbank_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .idx      (idx),
        .pll_upd  (pll_upd),
        .chan_upd (chan_upd)
    );

    // R1: a write without the key is never followed by a strobe
    p_badkey_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[DATA_W-1 -: KEY_W] != WR_KEY)
        |=> (pll_upd == '0 && chan_upd == '0));

    // R3: a misaligned write is never followed by a strobe
    p_unaligned_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[1:0] != 2'b00)
        |=> (pll_upd == '0 && chan_upd == '0));
endmodule

// File: tb/clkbank_regs_bench.sv
// Directed bench for the clock control register bank.
module clkbank_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  pll_upd;
    logic [15:0] chan_upd;

    int total = 0;
    int bad = 0;
    logic [4:0]  cap_pll;
    logic [15:0] cap_chan;

    clkbank_regs u_clkbank_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_upd(pll_upd), .chan_upd(chan_upd)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one word; capture the strobes one cycle later
    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        cap_pll = pll_upd; cap_chan = chan_upd;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R8 pll_upd after reset", 32'(pll_upd), 32'h0);
        check("R8 chan_upd after reset", 32'(chan_upd), 32'h0);
        rd(13'h1204, d);
        check("R8 reg zero after reset", d, 32'h0);
        wr(13'h0C00, 32'h5A12_3456);
        do_reset();
        rd(13'h0C00, d);
        check("R8 reset clears written reg", d, 32'h0);
    endtask

    task automatic t_key();
        logic [31:0] d;
        wr(13'h1208, 32'h5AAB_CDEF);
        rd(13'h1208, d);
        check("R2 key stripped", d, 32'h00AB_CDEF);
        wr(13'h1208, 32'hA511_1111);
        check("R1 bad key no pll strobe", 32'(cap_pll), 32'h0);
        check("R1 bad key no chan strobe", 32'(cap_chan), 32'h0);
        rd(13'h1208, d);
        check("R1 bad key keeps value", d, 32'h00AB_CDEF);
    endtask

    task automatic t_align();
        logic [31:0] d;
        wr(13'h120A, 32'h5A00_0077);
        check("R3 misaligned write no strobe", 32'(cap_chan), 32'h0);
        rd(13'h1208, d);
        check("R3 misaligned write ignored", d, 32'h00AB_CDEF);
        rd(13'h1209, d);
        check("R3 misaligned read zero", d, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(13'h0080, 32'h5A00_FFFF);
        check("R10 lock offset no strobe", 32'(cap_pll), 32'h0);
        rd(13'h0080, d);
        check("R4 lock all set, stored ignored", d, 32'h0000_001F);
        wr(13'h1040, 32'h5A01_0000);
        rd(13'h0080, d);
        check("R4 power-down clears lock", d, 32'h0000_001B);
        wr(13'h0100, 32'h5A00_0100);
        rd(13'h0080, d);
        check("R4 analog reset clears lock", d, 32'h0000_001A);
        wr(13'h1040, 32'h5A00_0000);
        rd(13'h0080, d);
        check("R4 lock returns", d, 32'h0000_001E);
    endtask

    task automatic t_mgr();
        wr(13'h010C, 32'h5A00_0000);
        check("R5 mgr3 pll strobe", 32'(cap_pll), 32'h08);
        check("R9 mgr3 channel fanout", 32'(cap_chan), 32'h7000);
        wr(13'h0110, 32'h5A00_0000);
        check("R9 mgr4 channel fanout", 32'(cap_chan), 32'h8000);
        wr(13'h0100, 32'h5A00_0000);
        check("R5 mgr0 pll strobe", 32'(cap_pll), 32'h01);
        check("R9 mgr0 channel fanout", 32'(cap_chan), 32'h000F);
        wr(13'h0104, 32'h5A00_0000);
        check("R9 mgr1 channel fanout", 32'(cap_chan), 32'h00F0);
        @(negedge clk);
        check("R10 strobe lasts one cycle", 32'({pll_upd, chan_upd}), 32'h0);
    endtask

    task automatic t_ana();
        wr(13'h1024, 32'h5A00_0001);
        check("R6 fraction write pll1", 32'(cap_pll), 32'h02);
        check("R6 no channel strobe", 32'(cap_chan), 32'h0);
        wr(13'h1094, 32'h5A00_0001);
        check("R6 tuning slot5 pll4", 32'(cap_pll), 32'h10);
        wr(13'h1018, 32'h5A00_0003);
        check("R10 slot6 unmapped no strobe", 32'({cap_pll, cap_chan}), 32'h0);
    endtask

    task automatic t_chan();
        logic [31:0] d;
        wr(13'h123C, 32'h5A00_0042);
        check("R7 channel15 strobe", 32'(cap_chan), 32'h8000);
        check("R7 no pll strobe", 32'(cap_pll), 32'h0);
        wr(13'h1200, 32'h5A00_0001);
        check("R7 channel0 strobe", 32'(cap_chan), 32'h0001);
        wr(13'h0C00, 32'h5A12_3456);
        check("R10 unmapped no strobe", 32'({cap_pll, cap_chan}), 32'h0);
        rd(13'h0C00, d);
        check("R10 unmapped stored", d, 32'h0012_3456);
        @(negedge clk);
        check("R11 rdata holds", bus_rdata, 32'h0012_3456);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_key();
                t_align();
                t_lock();
                t_mgr();
                t_ana();
                t_chan();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule